// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs the host end of a three-wire link to a 12-bit successive-approximation converter. The converter is driven by a chip-select line and a data clock, and it returns its result on one data line. Working from the system clock, the controller builds a data clock of `2*HALF_DIV` system cycles per period. On a start request it pulls chip select low and issues the clock pulses. It samples the returned line on each rising data-clock edge, because the converter changes it on falling edges. The first three captures are thrown away: two of them cover the converter's output-enable delay and one is the null bit. The twelve captures after those form the result, most significant bit first.

Two options are chosen per frame. The first is a reduced-resolution frame, which raises chip select after N result bits and returns only those bits. The second is a checked frame, which keeps clocking while the converter repeats bits 1 to 11 in least-significant-first order and flags any disagreement with the first copy. After reset the controller runs one normal frame on its own to settle the converter's track-and-hold. It reports nothing for that frame. The host side is a start / busy / done handshake. Chip select stays high for at least one data-clock period between frames.

Top module: `sadc_reader`

## Requirements
- R1: `adc_cs_n` is 1 in reset and while idle. It drops on the system edge that accepts a frame and rises on the edge that ends the last pulse's low phase. It then stays high for at least `2*HALF_DIV` system cycles before the next frame.
- R2: `adc_sclk` is 0 whenever chip select is high. Each pulse is `HALF_DIV` cycles high followed by `HALF_DIV` cycles low. The first rise comes `HALF_DIV` cycles after chip select falls.
- R3: `adc_sdo` is captured at each data-clock rise. Captures 0, 1 and 2 (the enable delay and the null bit) are discarded. Capture 3 goes to `data_out[11]` and capture 14 goes to `data_out[0]`.
- R4: A normal frame (`short_en`=0, `check_en`=0) issues exactly 16 data-clock pulses.
- R5: With `short_en`=1 and `short_len`=N, where N is from 1 to 11, the frame issues 3+N pulses. `data_out` then holds the N captured bits at the top and zeros below. A `short_len` of 0 or 12 or more gives a full normal frame.
- R6: With `check_en`=1 and no valid short length, the frame issues 26 pulses. Captures 15 to 25 carry bits 1 to 11 in that order. `cmp_err` is 1 with `done` if any of them differs from the same bit of the first copy. In every other frame `cmp_err` is 0.
- R7: `done` is high for exactly one system cycle, on the cycle chip select rises. `data_out` and `cmp_err` update with it and hold until the next `done`.
- R8: After reset, one normal 16-pulse frame runs without a start request and raises no `done`.
- R9: `busy` is 1 from frame acceptance until the chip-select gap ends. A start request while `busy` is 1 is ignored.
- R10: `short_en`, `short_len` and `check_en` are sampled when a frame is accepted. Changing them during the frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, taken while idle |
| short_en | input | 1 | Select reduced-resolution frame |
| short_len | input | 4 | Result bits kept in a reduced frame |
| check_en | input | 1 | Select checked frame with repeat comparison |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle result strobe |
| data_out | output | 12 | Assembled result word |
| cmp_err | output | 1 | Repeat mismatch flag, valid with done |

## Verification
The converter model in the bench drives 1 during the two enable-delay captures and 0 for the null bit. A design that skips the wrong number of captures therefore shifts a wrong value into the MSB and returns a word off by a factor of two. Reduced frames are run at lengths 1, 5 and 11, plus the fallback lengths 0 and 13, so that a pulse count off by one or an unmasked low bit shows up in both the pulse tally and the word. Checked frames are run with a clean repeat and with a single flipped repeat bit; a design that compares the wrong positions either misses the flip or flags a clean frame. Start requests during the dummy frame and mid-frame, and configuration changes mid-frame, expose designs that accept an extra frame or resample their options.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int WORD_W      = 12;
  localparam int SKIP_PULSES = 3;
  localparam int NORM_PULSES = 16;
  localparam int REP_BITS    = WORD_W - 1;
  localparam int PIDX_W      = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_GAP
  } seq_t;

  typedef struct packed {
    logic       shorten;
    logic [3:0] nbits;
    logic       check;
    logic       dummy;
  } cfg_t;

  // reduced frame only when the requested length is below a full word
  function automatic logic short_active(cfg_t c);
    return c.shorten && (c.nbits != 4'd0) && (c.nbits < 4'(WORD_W));
  endfunction

  function automatic logic check_active(cfg_t c);
    return c.check && !short_active(c);
  endfunction

  function automatic logic [PIDX_W-1:0] frame_pulses(cfg_t c);
    if (short_active(c))
      return PIDX_W'(SKIP_PULSES) + PIDX_W'(c.nbits);
    if (c.check)
      return PIDX_W'(SKIP_PULSES + WORD_W + REP_BITS);
    return PIDX_W'(NORM_PULSES);
  endfunction

endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int HALF_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
  import sadc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 cap,
  input  logic [PIDX_W-1:0]    pidx,
  input  logic                 sdo,
  output logic [WORD_W-1:0]    word,
  output logic [WORD_W-1:1]    rep
);
  logic [PIDX_W-1:0] rel;
  logic [PIDX_W-1:0] rrel;
  logic              past_skip;
  logic              in_word;
  logic              in_rep;
  logic [3:0]        wpos;
  logic [3:0]        rpos;

  assign past_skip = (pidx >= PIDX_W'(SKIP_PULSES));
  assign rel       = pidx - PIDX_W'(SKIP_PULSES);
  assign in_word   = past_skip && (rel < PIDX_W'(WORD_W));
  assign in_rep    = past_skip && (rel >= PIDX_W'(WORD_W))
                     && (rel < PIDX_W'(WORD_W + REP_BITS));
  assign wpos      = 4'(WORD_W - 1) - rel[3:0];
  assign rrel      = rel - PIDX_W'(WORD_W - 1);
  assign rpos      = rrel[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      rep  <= '0;
    end else if (clear) begin
      word <= '0;
      rep  <= '0;
    end else if (cap) begin
      if (in_word)     word[wpos] <= sdo;
      else if (in_rep) rep[rpos]  <= sdo;
    end
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int HALF_DIV = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              short_en,
  input  logic [3:0]        short_len,
  input  logic              check_en,
  input  logic              adc_sdo,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] data_out,
  output logic              cmp_err
);
  seq_t              st;
  cfg_t              cfg;
  logic [PIDX_W-1:0] pidx;
  logic [PIDX_W-1:0] total;
  logic [PIDX_W-1:0] rise_idx;
  logic              gap_half;
  logic              dummy_pend;
  logic              tick;
  logic              at_last;
  logic              accept;
  logic              rise_evt;
  logic              last_evt;
  logic [WORD_W-1:0] word_w;
  logic [WORD_W-1:1] rep_w;

  assign busy     = (st != ST_IDLE);
  assign total    = frame_pulses(cfg);
  assign at_last  = (pidx == total - PIDX_W'(1));
  assign accept   = (st == ST_IDLE) && (dummy_pend || start);
  assign rise_evt = tick && ((st == ST_SETUP) || (st == ST_LOW && !at_last));
  assign last_evt = tick && (st == ST_LOW) && at_last;
  assign rise_idx = (st == ST_SETUP) ? '0 : pidx + PIDX_W'(1);

  sadc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  sadc_capture u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .cap  (rise_evt),
    .pidx (rise_idx),
    .sdo  (adc_sdo),
    .word (word_w),
    .rep  (rep_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cfg        <= '0;
      pidx       <= '0;
      gap_half   <= 1'b0;
      dummy_pend <= 1'b1;
      adc_cs_n   <= 1'b1;
      adc_sclk   <= 1'b0;
      done       <= 1'b0;
      data_out   <= '0;
      cmp_err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            cfg.shorten <= dummy_pend ? 1'b0 : short_en;
            cfg.nbits   <= dummy_pend ? 4'd0 : short_len;
            cfg.check   <= dummy_pend ? 1'b0 : check_en;
            cfg.dummy   <= dummy_pend;
            dummy_pend  <= 1'b0;
            pidx        <= '0;
            adc_cs_n    <= 1'b0;
            st          <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            adc_sclk <= 1'b1;
            pidx     <= '0;
            st       <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            adc_sclk <= 1'b0;
            st       <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (last_evt) begin
            adc_cs_n <= 1'b1;
            gap_half <= 1'b0;
            st       <= ST_GAP;
            if (!cfg.dummy) begin
              done     <= 1'b1;
              data_out <= word_w;
              cmp_err  <= check_active(cfg) && (word_w[WORD_W-1:1] != rep_w);
            end
          end else if (rise_evt) begin
            pidx     <= rise_idx;
            adc_sclk <= 1'b1;
            st       <= ST_HIGH;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) st <= ST_IDLE;
            else          gap_half <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int HALF_DIV = 125
) (
  input logic        clk,
  input logic        rst_n,
  input logic        adc_cs_n,
  input logic        adc_sclk,
  input logic        busy,
  input logic        done,
  input logic [11:0] data_out,
  input logic        cmp_err,
  input logic        rise_evt,
  input logic        last_evt
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= 16'hFFFF;
    else if (!adc_cs_n)       hi_cnt <= 16'd0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (32'(hi_cnt) >= 2 * HALF_DIV));

  p_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> (adc_cs_n && !adc_sclk));

  p_idle_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (!adc_sclk ##1 (adc_sclk && !adc_cs_n)));

  p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(adc_cs_n));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(data_out) && $stable(cmp_err)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);
endmodule

bind sadc_reader sadc_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk),
  .busy    (busy),
  .done    (done),
  .data_out(data_out),
  .cmp_err (cmp_err),
  .rise_evt(rise_evt),
  .last_evt(last_evt)
);

// File: tb/test_sadc_reader.sv
module test_sadc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        short_en = 1'b0;
  logic [3:0]  short_len = 4'd0;
  logic        check_en = 1'b0;
  logic        adc_sdo;
  logic        adc_cs_n;
  logic        adc_sclk;
  logic        busy;
  logic        done;
  logic [11:0] data_out;
  logic        cmp_err;

  int checks = 0;
  int errors = 0;

  sadc_reader #(.HALF_DIV(HALF)) i_sadc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .short_en(short_en),
    .short_len(short_len), .check_en(check_en), .adc_sdo(adc_sdo),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .busy(busy), .done(done),
    .data_out(data_out), .cmp_err(cmp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- converter model ----------------
  logic [11:0] dev_word = 12'hA5A;
  int          flip_at  = -1;
  int          fall_cnt = 0;
  int          rises    = 0;

  always @(negedge adc_cs_n) fall_cnt = 0;
  always @(negedge adc_sclk) fall_cnt = fall_cnt + 1;
  always @(posedge adc_sclk) rises = rises + 1;

  function automatic logic dev_bit(int p);
    if (p < 2)  return 1'b1;                 // enable delay: junk high
    if (p == 2) return 1'b0;                 // null bit
    if (p <= 14) return dev_word[14 - p];    // MSB first
    if (p <= 25) return dev_word[p - 14] ^ (p == flip_at); // LSB-first repeat
    return 1'b0;
  endfunction

  assign adc_sdo = dev_bit(fall_cnt);

  // ---------------- expectations ----------------
  function automatic bit short_ok(logic sh, logic [3:0] n);
    return sh && (n >= 1) && (n <= 11);
  endfunction

  function automatic int pulses_for(logic sh, logic [3:0] n, logic ck);
    if (short_ok(sh, n)) return 3 + int'(n);
    return ck ? 26 : 16;
  endfunction

  function automatic logic [11:0] word_for(logic [11:0] w, logic sh, logic [3:0] n);
    logic [11:0] m = 12'hFFF;
    if (short_ok(sh, n)) for (int i = 0; i < 12 - int'(n); i++) m[i] = 1'b0;
    return w & m;
  endfunction

  function automatic bit err_for(logic sh, logic [3:0] n, logic ck, int fa);
    return ck && !short_ok(sh, n) && (fa >= 15) && (fa <= 25);
  endfunction

  // ---------------- cycle model ----------------
  bit          m_live = 0, m_dummy = 0, dummy_todo = 1;
  int          d = 0, P = 16, end_d = 0;
  bit          m_cs_n = 1, m_sclk = 0, m_done = 0, m_busy = 0;
  logic [11:0] exp_data = 12'h0, pend_data = 12'h0;
  bit          exp_err = 0, pend_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 0; dummy_todo = 1; exp_data = 12'h0; exp_err = 0;
      m_cs_n = 1; m_sclk = 0; m_done = 0; m_busy = 0;
    end else begin
      if (!m_live) begin
        if (dummy_todo || start) begin
          m_live = 1; d = 0; m_dummy = dummy_todo; dummy_todo = 0;
          P = m_dummy ? 16 : pulses_for(short_en, short_len, check_en);
          pend_data = word_for(dev_word, short_en, short_len);
          pend_err  = err_for(short_en, short_len, check_en, flip_at);
        end
      end else d = d + 1;
      if (m_live) begin
        end_d  = HALF + 2 * HALF * P;
        m_cs_n = (d >= end_d);
        m_sclk = (d >= HALF) && (d < end_d) && (((d - HALF) % (2 * HALF)) < HALF);
        m_done = (d == end_d) && !m_dummy;
        if (m_done) begin exp_data = pend_data; exp_err = pend_err; end
        m_busy = (d < end_d + 2 * HALF);
        if (!m_busy) m_live = 0;
      end else begin
        m_cs_n = 1; m_sclk = 0; m_done = 0; m_busy = 0;
      end
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  bit cmp_on = 0;
  always @(posedge clk) cmp_on <= 1'b1;

  always @(negedge clk) if (cmp_on) begin
    chk("R1",  "adc_cs_n", int'(adc_cs_n), int'(m_cs_n));
    chk("R2",  "adc_sclk", int'(adc_sclk), int'(m_sclk));
    chk("R7",  "done",     int'(done),     int'(m_done));
    chk("R9",  "busy",     int'(busy),     int'(m_busy));
    chk("R3",  "data_out", int'(data_out), int'(exp_data));
    chk("R6",  "cmp_err",  int'(cmp_err),  int'(exp_err));
  end

  int done_cnt = 0;
  int frames   = 0;
  always @(posedge clk) if (rst_n && done) done_cnt++;

  task automatic run_frame(input logic [11:0] w, input logic sh, input logic [3:0] n,
                           input logic ck, input int fa, input bit wiggle, input string tag);
    @(negedge clk);
    dev_word = w; flip_at = fa; short_en = sh; short_len = n; check_en = ck; rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (wiggle) begin
      repeat (10) @(negedge clk);
      short_en = ~sh; short_len = 4'd2; check_en = ~ck; start = 1'b1;  // R10, R9
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
    chk(tag, "pulse count", rises, pulses_for(sh, n, ck));
    chk(tag, "word", int'(data_out), int'(word_for(w, sh, n)));
    chk("R6", "mismatch flag", int'(cmp_err), int'(err_for(sh, n, ck, fa)));
    frames++;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "cs_n in reset", int'(adc_cs_n), 1);
    chk("R9", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    // R8: dummy frame runs by itself; start during it is ignored (R9)
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    chk("R8", "dummy pulse count", rises, 16);
    chk("R8", "no done for dummy", done_cnt, 0);

    run_frame(12'hB37, 0, 4'd0,  0, -1, 0, "R4");
    run_frame(12'h800, 0, 4'd0,  0, -1, 0, "R3");
    run_frame(12'h001, 0, 4'd0,  0, -1, 0, "R3");
    run_frame(12'hFFF, 1, 4'd5,  0, -1, 0, "R5");
    run_frame(12'h800, 1, 4'd1,  0, -1, 0, "R5");
    run_frame(12'hFFF, 1, 4'd11, 0, -1, 0, "R5");
    run_frame(12'h6C9, 1, 4'd0,  0, -1, 0, "R5");
    run_frame(12'h6C9, 1, 4'd13, 0, -1, 0, "R5");
    run_frame(12'h5C3, 0, 4'd0,  1, -1, 0, "R6");
    run_frame(12'h5C3, 0, 4'd0,  1, 20, 0, "R6");
    run_frame(12'hA5A, 0, 4'd0,  1, 25, 0, "R6");
    run_frame(12'h3F0, 1, 4'd6,  1, 20, 0, "R5");
    run_frame(12'h9E1, 0, 4'd0,  0, -1, 1, "R10");
    run_frame(12'h9E1, 0, 4'd0,  1, 17, 1, "R10");
    chk("R8", "done pulses vs frames", done_cnt, frames);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule